// File: doc/BRIEF.md
# Scan Pattern Application Sequencer

This block runs a stored scan test on one or more scan chains of equal or bounded length. It drives the scan enable, the serial input of every chain and a clock-enable pulse that advances the chains. It also compares every bit that leaves the chains with an expected bit supplied from outside. Pattern storage sits outside the block. The sequencer publishes the index of the pattern being loaded and the position of the bit within the chain. The surrounding logic answers with the stimulus bits and the expected response bits for that slot.

Four test modes exist. Stuck-at mode shifts each pattern in slowly and captures it once. The response of a pattern is unloaded while the next pattern is loaded. Launch-on-capture mode shifts slowly and then issues two back-to-back at-speed captures. Launch-on-shift mode makes the final shift at speed and follows it at once with an at-speed capture. Flush mode passes a 0,0,1,1 sequence through the chains with no capture and checks it at the far end.

Only one clock is used. A slow step is one clock-enable pulse every `SLOW_DIV` cycles. A fast step is a pulse in consecutive cycles.

Top module: `scan_apply_ctrl`

## Requirements
- R1: After reset, `scan_en`, `clk_en`, `at_speed`, `busy`, `done` and `fail` are all 0.
- R2: In stuck-at mode (`mode`=0), each pattern takes `CHAIN_LEN` steps with `scan_en`=1 followed by one step with `scan_en`=0. A final unload of `CHAIN_LEN` steps follows the last pattern. A run of N patterns therefore takes N*(CHAIN_LEN+1)+CHAIN_LEN steps, and all of them are slow.
- R3: A step is a one-cycle `clk_en` pulse. A slow step (`at_speed`=0) comes exactly `SLOW_DIV` cycles after the previous step of the run. A fast step (`at_speed`=1) comes one cycle after the previous step.
- R4: In launch-on-capture mode (`mode`=1), each pattern takes `CHAIN_LEN` slow shift steps and then two fast steps with `scan_en`=0. This gives N*CHAIN_LEN+CHAIN_LEN slow shifts and 2N fast captures.
- R5: In launch-on-shift mode (`mode`=2), each pattern takes `CHAIN_LEN`-1 slow shifts, then one fast shift, then one fast capture. The final unload is slow.
- R6: A bit is compared when a shift step unloads a response: during the load of pattern 1 or later, and during the final unload. The comparison is between `scan_out` and `exp_bits`. `pat_idx` is the pattern being loaded, which equals N during the final unload. `exp_bits` holds response bits of pattern `pat_idx`-1, and `bit_idx` counts the shift steps of the current pass from 0. Any mismatch sets `fail`, which holds until the next accepted start.
- R7: Flush mode (`mode`=3) makes 2*`CHAIN_LEN` slow shift steps and no capture. Shift step k drives bit 1 of k on every chain. In the second half, the bit at `scan_out` on pass step b is checked against bit 1 of b, and a mismatch sets `fail`.
- R8: After the last step, `done` pulses for one cycle. On the next cycle `busy`, `done` and `scan_en` are 0. A `start` received while `busy` is ignored.
- R9: A start with `pat_num`=0 in a mode other than flush produces `done` with no steps. Flush mode ignores `pat_num`.
- R10: On load shift steps (`pat_idx` < N), `scan_in` equals `stim_bits`. During the final unload, `scan_in` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted when idle) |
| mode | input | 2 | 0 stuck-at, 1 launch-on-capture, 2 launch-on-shift, 3 flush |
| pat_num | input | PW | Number of patterns N |
| stim_bits | input | NUM_CHAINS | Stimulus bit per chain for (`pat_idx`, `bit_idx`) |
| exp_bits | input | NUM_CHAINS | Expected unloaded bit per chain |
| scan_out | input | NUM_CHAINS | Serial outputs of the chains |
| scan_en | output | 1 | 1 = shift, 0 = capture |
| scan_in | output | NUM_CHAINS | Serial inputs of the chains |
| clk_en | output | 1 | Step pulse that advances the chains |
| at_speed | output | 1 | Current step is fast |
| pat_idx | output | PW | Pattern being loaded |
| bit_idx | output | BW | Shift step within the current pass |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag |

## Verification
The assertions assume the following about the environment. The chain model advances only on `clk_en`. `stim_bits` and `exp_bits` are combinational answers to the published indices, and `start` is a single-cycle pulse. The bench keeps to this: it models the chains and the capture logic itself, and answers the indices from stored random patterns. It draws modes and pattern counts from a seeded generator, with N limited to the bench's pattern store. It raises `start` while a run is in progress only to check that it is ignored.

// File: rtl/scan_ctrl_pkg.sv
package scan_ctrl_pkg;
   typedef enum logic [1:0] {
      MODE_STUCK = 2'd0,
      MODE_LOC   = 2'd1,
      MODE_LOS   = 2'd2,
      MODE_FLUSH = 2'd3
   } test_mode_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SHIFT,
      PH_LAUNCH,
      PH_CAPT,
      PH_DONE
   } phase_e;
endpackage

// File: rtl/scan_tick_gen.sv
module scan_tick_gen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic fast,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("scan_tick_gen: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_nodiv
         assign tick = active;
      end else begin : g_div
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt;

         assign tick = active && (fast || cnt == CW'(DIV - 1));

         always_ff @(posedge clk) begin
            if (!rst_n)              cnt <= '0;
            else if (!active || tick) cnt <= '0;
            else                      cnt <= cnt + CW'(1);
         end

         // two slow steps never fall in adjacent cycles
         assert_slow_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && !fast) |=> !(tick && !fast));
      end
   endgenerate
endmodule

// File: rtl/scan_seq.sv
module scan_seq
   import scan_ctrl_pkg::*;
#(
   parameter int L  = 16,
   parameter int PW = 8,
   localparam int BW = (L > 1) ? $clog2(L) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    mode,
   input  logic [PW-1:0] pat_num,
   input  logic          tick,
   output logic          accept,
   output logic          active,
   output logic          busy,
   output logic          done,
   output logic          scan_en,
   output logic          fast,
   output logic          unload,
   output logic          flush_on,
   output logic          flush_bit,
   output logic          flush_exp,
   output logic          cmp_en,
   output logic [PW-1:0] pat_idx,
   output logic [BW-1:0] bit_idx
);
   localparam logic [BW-1:0] LAST = BW'(L - 1);

   phase_e        phase;
   test_mode_e    mode_q;
   logic [PW-1:0] n_q;
   logic [PW-1:0] pat;
   logic [BW-1:0] bitc;
   logic [BW:0]   fl_cnt;
   logic          unl;
   logic [BW:0]   bit_ext;

   assign accept    = start && (phase == PH_IDLE);
   assign active    = (phase == PH_SHIFT) || (phase == PH_LAUNCH) || (phase == PH_CAPT);
   assign busy      = active;
   assign done      = (phase == PH_DONE);
   assign scan_en   = (phase == PH_SHIFT);
   assign unload    = unl;
   assign flush_on  = (mode_q == MODE_FLUSH);
   assign flush_bit = fl_cnt[1];
   assign bit_ext   = {1'b0, bitc};
   assign flush_exp = bit_ext[1];
   assign pat_idx   = pat;
   assign bit_idx   = bitc;
   assign cmp_en    = tick && (phase == PH_SHIFT) &&
                      (unl || (mode_q != MODE_FLUSH && pat != '0));

   always_comb begin
      case (mode_q)
         MODE_LOC: fast = (phase == PH_LAUNCH) || (phase == PH_CAPT);
         MODE_LOS: fast = (phase == PH_CAPT) ||
                          ((phase == PH_SHIFT) && !unl && (bitc == LAST));
         default:  fast = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         mode_q <= MODE_STUCK;
         n_q    <= '0;
         pat    <= '0;
         bitc   <= '0;
         unl    <= 1'b0;
         fl_cnt <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  mode_q <= test_mode_e'(mode);
                  n_q    <= pat_num;
                  pat    <= '0;
                  bitc   <= '0;
                  unl    <= 1'b0;
                  fl_cnt <= '0;
                  if (test_mode_e'(mode) != MODE_FLUSH && pat_num == '0)
                     phase <= PH_DONE;
                  else
                     phase <= PH_SHIFT;
               end
            end
            PH_SHIFT: begin
               if (tick) begin
                  fl_cnt <= fl_cnt + (BW+1)'(1);
                  if (bitc == LAST) begin
                     bitc <= '0;
                     if (unl)                       phase <= PH_DONE;
                     else if (mode_q == MODE_FLUSH) unl   <= 1'b1;
                     else if (mode_q == MODE_LOC)   phase <= PH_LAUNCH;
                     else                           phase <= PH_CAPT;
                  end else begin
                     bitc <= bitc + BW'(1);
                  end
               end
            end
            PH_LAUNCH: begin
               if (tick) phase <= PH_CAPT;
            end
            PH_CAPT: begin
               if (tick) begin
                  pat <= pat + PW'(1);
                  if (pat + PW'(1) == n_q) unl <= 1'b1;
                  phase <= PH_SHIFT;
               end
            end
            PH_DONE:  phase <= PH_IDLE;
            default:  phase <= PH_IDLE;
         endcase
      end
   end

   assert_launch_capt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LAUNCH && tick) |=> (phase == PH_CAPT && fast));

   assert_capt_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CAPT && tick) |=> scan_en);

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!busy && !done && !scan_en));

   assert_bit_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bitc <= LAST);
endmodule

// File: rtl/scan_cmp.sv
module scan_cmp #(
   parameter int C = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         cmp_en,
   input  logic         flush_on,
   input  logic         flush_exp,
   input  logic [C-1:0] scan_out,
   input  logic [C-1:0] exp_bits,
   output logic         fail
);
   logic [C-1:0] want;

   assign want = flush_on ? {C{flush_exp}} : exp_bits;

   always_ff @(posedge clk) begin
      if (!rst_n)                          fail <= 1'b0;
      else if (clr)                        fail <= 1'b0;
      else if (cmp_en && scan_out != want) fail <= 1'b1;
   end

   assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !clr) |=> fail);
endmodule

// File: rtl/scan_apply_ctrl.sv
module scan_apply_ctrl #(
   parameter int NUM_CHAINS = 4,
   parameter int CHAIN_LEN  = 16,
   parameter int MAX_PAT    = 255,
   parameter int SLOW_DIV   = 4,
   localparam int PW = $clog2(MAX_PAT + 1),
   localparam int BW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [1:0]            mode,
   input  logic [PW-1:0]         pat_num,
   input  logic [NUM_CHAINS-1:0] stim_bits,
   input  logic [NUM_CHAINS-1:0] exp_bits,
   input  logic [NUM_CHAINS-1:0] scan_out,
   output logic                  scan_en,
   output logic [NUM_CHAINS-1:0] scan_in,
   output logic                  clk_en,
   output logic                  at_speed,
   output logic [PW-1:0]         pat_idx,
   output logic [BW-1:0]         bit_idx,
   output logic                  busy,
   output logic                  done,
   output logic                  fail
);
   generate
      if (CHAIN_LEN < 2) begin : g_bad_len
         $error("scan_apply_ctrl: CHAIN_LEN must be at least 2");
      end
      if (NUM_CHAINS < 1) begin : g_bad_chains
         $error("scan_apply_ctrl: NUM_CHAINS must be at least 1");
      end
      if (MAX_PAT < 1) begin : g_bad_pat
         $error("scan_apply_ctrl: MAX_PAT must be at least 1");
      end
   endgenerate

   logic accept, active, fast, tick, unload;
   logic flush_on, flush_bit, flush_exp, cmp_en;

   scan_tick_gen #(.DIV(SLOW_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .fast   (fast),
      .tick   (tick)
   );

   scan_seq #(.L(CHAIN_LEN), .PW(PW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mode      (mode),
      .pat_num   (pat_num),
      .tick      (tick),
      .accept    (accept),
      .active    (active),
      .busy      (busy),
      .done      (done),
      .scan_en   (scan_en),
      .fast      (fast),
      .unload    (unload),
      .flush_on  (flush_on),
      .flush_bit (flush_bit),
      .flush_exp (flush_exp),
      .cmp_en    (cmp_en),
      .pat_idx   (pat_idx),
      .bit_idx   (bit_idx)
   );

   scan_cmp #(.C(NUM_CHAINS)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (accept),
      .cmp_en    (cmp_en),
      .flush_on  (flush_on),
      .flush_exp (flush_exp),
      .scan_out  (scan_out),
      .exp_bits  (exp_bits),
      .fail      (fail)
   );

   always_comb begin
      if (!scan_en)      scan_in = '0;
      else if (flush_on) scan_in = {NUM_CHAINS{flush_bit}};
      else if (unload)   scan_in = '0;
      else               scan_in = stim_bits;
   end

   assign clk_en   = tick;
   assign at_speed = fast;
endmodule

// File: tb/sim_scan_apply_ctrl.sv
module sim_scan_apply_ctrl;
   localparam int TC = 2;
   localparam int TL = 6;
   localparam int TD = 3;
   localparam int TP = 15;
   localparam int PW = $clog2(TP + 1);
   localparam int BW = $clog2(TL);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [1:0] mode = 2'd0;
   logic [PW-1:0] pat_num = '0;
   logic [TC-1:0] stim_bits, exp_bits, scan_out, scan_in;
   logic scan_en, clk_en, at_speed, busy, done, fail;
   logic [PW-1:0] pat_idx;
   logic [BW-1:0] bit_idx;

   always #10 clk = ~clk;

   scan_apply_ctrl #(.NUM_CHAINS(TC), .CHAIN_LEN(TL), .MAX_PAT(TP), .SLOW_DIV(TD)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pat_num(pat_num),
      .stim_bits(stim_bits), .exp_bits(exp_bits), .scan_out(scan_out),
      .scan_en(scan_en), .scan_in(scan_in), .clk_en(clk_en), .at_speed(at_speed),
      .pat_idx(pat_idx), .bit_idx(bit_idx), .busy(busy), .done(done), .fail(fail));

   logic [TL-1:0] stim_m [0:7][0:TC-1];
   logic [TL-1:0] resp_m [0:7][0:TC-1];
   logic [TL-1:0] chain [0:TC-1];
   int n_cur = 0;
   int m_cur = 0;
   bit corrupt = 1'b0;
   bit stuck1 = 1'b0;
   int n_tests = 0;
   int n_fail = 0;

   function automatic logic [TL-1:0] cap_f(input logic [TL-1:0] v);
      return {v[TL-2:0], v[TL-1]} ^ {1'b0, v[TL-1:1]} ^ TL'(5);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   // stored pattern answers and expected responses
   always_comb begin
      int p, bi;
      p  = int'(pat_idx);
      bi = int'(bit_idx);
      for (int c = 0; c < TC; c++) begin
         stim_bits[c] = (p < n_cur && p < 8) ? stim_m[p][c][TL-1-bi] : 1'b0;
         exp_bits[c]  = (p >= 1 && p <= n_cur && p <= 8) ? resp_m[p-1][c][TL-1-bi] : 1'b0;
         if (corrupt && p == 1 && bi == 2 && c == 0) exp_bits[c] = ~exp_bits[c];
         scan_out[c]  = chain[c][TL-1] & ~(stuck1 && c == 1);
      end
   end

   // chain and capture-logic model
   always @(posedge clk) begin
      for (int c = 0; c < TC; c++) begin
         if (!rst_n)       chain[c] <= '0;
         else if (clk_en) chain[c] <= scan_en ? {chain[c][TL-2:0], scan_in[c]} : cap_f(chain[c]);
      end
   end

   // step monitor
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;
   bit running = 1'b0;
   bit have_last = 1'b0;
   int last_tick = 0;
   int sh_slow = 0, sh_fast = 0, cp_slow = 0, cp_fast = 0;
   int gap_err = 0, si_err = 0, fl_step = 0;

   always @(negedge clk) begin
      if (running && clk_en) begin
         if (have_last) begin
            if (at_speed && cyc - last_tick != 1) gap_err++;
            if (!at_speed && cyc - last_tick != TD) gap_err++;
         end
         have_last = 1'b1;
         last_tick = cyc;
         if (scan_en && at_speed)   sh_fast++;
         if (scan_en && !at_speed)  sh_slow++;
         if (!scan_en && at_speed)  cp_fast++;
         if (!scan_en && !at_speed) cp_slow++;
         if (scan_en) begin
            if (m_cur == 3) begin
               if (scan_in != {TC{1'(fl_step >> 1)}}) si_err++;
               fl_step++;
            end else if (int'(pat_idx) < n_cur) begin
               if (scan_in != stim_bits) si_err++;
            end else if (scan_in != '0) si_err++;
         end
      end
   end

   task automatic run(input int m, input int n, input bit corr, input bit stk,
                      input bit exp_fail, input bit mid_start, input string tag);
      int e_ss, e_sf, e_cs, e_cf, k;
      bit seen;
      m_cur = m; n_cur = n; corrupt = corr; stuck1 = stk;
      for (int p = 0; p < 8; p++)
         for (int c = 0; c < TC; c++) begin
            stim_m[p][c] = TL'($urandom);
            resp_m[p][c] = (m == 1) ? cap_f(cap_f(stim_m[p][c])) : cap_f(stim_m[p][c]);
         end
      sh_slow = 0; sh_fast = 0; cp_slow = 0; cp_fast = 0;
      gap_err = 0; si_err = 0; fl_step = 0; have_last = 1'b0;
      @(negedge clk);
      mode = 2'(m); pat_num = PW'(n); start = 1'b1;
      running = 1'b1;
      @(negedge clk);
      start = 1'b0;
      seen = 1'b0;
      k = 0;
      while (!seen && k < 3000) begin
         if (done) seen = 1'b1;
         else begin
            if (mid_start && k == 10) begin start = 1'b1; pat_num = PW'(1); mode = 2'd0; end
            else start = 1'b0;
            @(negedge clk);
            k++;
         end
      end
      start = 1'b0;
      chk(seen, {"R8 done reached ", tag}, int'(seen), 1);
      e_ss = 0; e_sf = 0; e_cs = 0; e_cf = 0;
      case (m)
         0: begin e_ss = n*TL + (n > 0 ? TL : 0); e_cs = n; end
         1: begin e_ss = n*TL + (n > 0 ? TL : 0); e_cf = 2*n; end
         2: begin e_ss = n*(TL-1) + (n > 0 ? TL : 0); e_sf = n; e_cf = n; end
         default: e_ss = 2*TL;
      endcase
      chk(sh_slow == e_ss, {"R2/R4/R5/R7 slow shifts ", tag}, sh_slow, e_ss);
      chk(sh_fast == e_sf, {"R5 fast shifts ", tag}, sh_fast, e_sf);
      chk(cp_slow == e_cs, {"R2 slow captures ", tag}, cp_slow, e_cs);
      chk(cp_fast == e_cf, {"R4/R5 fast captures ", tag}, cp_fast, e_cf);
      chk(gap_err == 0, {"R3 step spacing ", tag}, gap_err, 0);
      chk(si_err == 0, {"R10 scan_in values ", tag}, si_err, 0);
      chk(fail == exp_fail, {"R6/R7 fail flag ", tag}, int'(fail), int'(exp_fail));
      @(negedge clk);
      running = 1'b0;
      chk(!done && !busy && !scan_en, {"R8 back to idle ", tag},
          int'({done, busy, scan_en}), 0);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({scan_en, clk_en, at_speed, busy, done, fail} == 6'b0, "R1 reset state",
          int'({scan_en, clk_en, at_speed, busy, done, fail}), 0);
      run(0, 3, 0, 0, 0, 0, "stuck N=3");
      chk(sh_slow + cp_slow == 3*(TL+1)+TL, "R2 total steps", sh_slow + cp_slow, 3*(TL+1)+TL);
      run(1, 2, 0, 0, 0, 0, "LOC N=2");
      run(2, 3, 0, 0, 0, 0, "LOS N=3");
      run(3, 0, 0, 0, 0, 0, "flush clean");
      run(3, 2, 0, 1, 1, 0, "flush stuck chain");
      run(0, 2, 1, 0, 1, 0, "stuck corrupt exp R6");
      run(0, 1, 0, 0, 0, 0, "fail cleared R6");
      run(0, 0, 0, 0, 0, 0, "empty R9");
      run(1, 0, 0, 0, 0, 0, "empty LOC R9");
      run(2, 2, 0, 0, 0, 1, "start while busy R8");
      run(2, 1, 0, 0, 0, 0, "LOS N=1");
      for (int i = 0; i < 8; i++) begin
         int rm, rn;
         rm = int'($urandom % 4);
         rn = 1 + int'($urandom % 4);
         run(rm, rn, 0, 0, 0, 0, "random");
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #3000000;
      n_tests++;
      n_fail++;
      $display("FAIL R8 watchdog: got %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule